// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block models the device side of a small serial EEPROM reached over chip select, a serial clock, a data-in line and a data-out line that can float. All four serial pins are sampled on a fast system clock, and a rising serial-clock edge is found by comparing the pin with its value one system clock earlier. After a start bit the block collects a two-bit opcode, an address and, for the two write commands, a data word. When the last required bit has arrived, the instruction runs against a register array.

Seven instructions are decoded: read, write, erase, erase-all, write-all, program-enable and program-disable. A program-enable latch guards the four commands that change the array. An organization input selects 8-bit or 16-bit words over the same storage. A programming operation starts a countdown timer measured in system clocks. While the timer runs, the data-out pin carries a busy/ready flag. Reads shift out one leading zero and then the word, MSB first.

Top module: `serial_eeprom_dev`

## Requirements
- R1: With `org` high the device uses 16-bit words and ADDR8_W-1 address bits. With `org` low it uses 8-bit words and ADDR8_W address bits. Byte address 2k is the low byte of 16-bit word k, and byte address 2k+1 is its high byte.
- R2: Inputs are taken only on a rising `sclk` edge. A start bit is the first rising edge with `cs` and `sdi` both high. Edges with `cs` low, and leading zeros with `cs` high, start nothing.
- R3: The opcode is sent MSB first: 10 read, 01 write, 11 erase. Opcode 00 takes its command from the two top address bits: 11 enable, 00 disable, 10 erase-all, 01 write-all. Address and data are sent MSB first after the opcode.
- R4: An instruction runs only once all of its bits have been clocked in. If `cs` falls earlier, the instruction is dropped and the array is left unchanged.
- R5: After the last bit of an instruction, further edges with `sdi` low have no effect until a new start bit arrives.
- R6: `sdo_en` is low except during read output and status reporting, and it is low whenever `cs` is low.
- R7: A read drives 0 after the rising edge that carries the last address bit. Each of the next 8 or 16 rising edges then drives the next data bit, MSB first. The edge after the last data bit floats `sdo`.
- R8: The program-enable latch is clear after reset, set by the enable command and cleared by the disable command. While it is clear, write, erase, erase-all and write-all change nothing and start no busy phase.
- R9: Read works whatever the state of the program-enable latch.
- R10: An accepted programming command drives `sdo` low with `sdo_en` high for PROG_CYCLES system clocks after the edge carrying its last bit, then drives it high. The flag shows whenever `cs` is high. It clears once `cs` is low with programming done. Start bits are refused while busy.
- R11: Erase sets the addressed word or byte to all ones, and erase-all sets every word to all ones. Write-all fills every word with the data; in 8-bit mode it fills both bytes of every word.
- R12: After reset the array reads as zero and `sdo_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| org | input | 1 | Word organization: 1 = 16-bit, 0 = 8-bit |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock, sampled on clk |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out value |
| sdo_en | output | 1 | Drive enable for sdo (low = high impedance) |

## Verification
The hardest state to reach from the pins is the busy/ready flag meeting other serial activity. This covers `cs` being lowered and raised again while programming runs, and start bits clocked while the device is busy. Both must leave the countdown alone and keep the flag visible. The stimulus builds three busy waits of exactly PROG_CYCLES clocks: one left alone, one with a `cs` bounce inside it, and one with start bits clocked during it. A reference model in the bench checks the output on every clock. It also changes organization between a 16-bit write and 8-bit reads of the same word, so that the byte mapping and the merge of a partial write are both checked.

// File: rtl/serial_eeprom_dev.sv
module serial_eeprom_dev #(
  parameter int ADDR8_W     = 7,
  parameter int PROG_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic org,
  input  logic cs,
  input  logic sclk,
  input  logic sdi,
  output logic sdo,
  output logic sdo_en
);
  localparam int WORDS  = 1 << (ADDR8_W - 1);
  localparam int CNT_W  = $clog2(ADDR8_W + 19);
  localparam int BUSY_W = $clog2(PROG_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_READ} st_t;

  st_t st;
  logic sclk_q;
  logic [CNT_W-1:0] cnt;
  logic [1:0] op;
  logic [ADDR8_W-1:0] addr;
  logic [15:0] data;
  logic wen;
  logic [BUSY_W-1:0] busy_cnt;
  logic stat;
  logic [15:0] rd_sh;
  logic [4:0] rd_left;
  logic do_q;
  logic [15:0] mem [WORDS];

  wire rise = sclk & ~sclk_q;
  wire busy = busy_cnt != '0;

  wire [CNT_W-1:0] aw = org ? CNT_W'(ADDR8_W - 1) : CNT_W'(ADDR8_W);
  wire [CNT_W-1:0] dw = org ? CNT_W'(16) : CNT_W'(8);
  wire in_op   = cnt < CNT_W'(2);
  wire in_addr = !in_op && (cnt < CNT_W'(2) + aw);

  wire [1:0]         op_n   = in_op ? {op[0], sdi} : op;
  wire [ADDR8_W-1:0] addr_n = in_addr ? {addr[ADDR8_W-2:0], sdi} : addr;
  wire [15:0]        data_n = (!in_op && !in_addr) ? {data[14:0], sdi} : data;
  wire [1:0]         ext    = org ? addr_n[ADDR8_W-2 -: 2] : addr_n[ADDR8_W-1 -: 2];

  wire has_data = (op_n == 2'b01) || (op_n == 2'b00 && ext == 2'b01);
  wire [CNT_W-1:0] need = CNT_W'(2) + aw + (has_data ? dw : '0);
  wire last  = (cnt == need - CNT_W'(1));
  wire start = cs && rise && sdi && !busy;

  wire [ADDR8_W-2:0] widx = org ? addr_n[ADDR8_W-2:0] : addr_n[ADDR8_W-1:1];
  wire hi = !org && addr_n[0];
  wire [15:0] cur = mem[widx];
  wire [15:0] wr_word = org ? data_n : (hi ? {data_n[7:0], cur[7:0]} : {cur[15:8], data_n[7:0]});
  wire [15:0] er_word = org ? 16'hFFFF : (hi ? {8'hFF, cur[7:0]} : {cur[15:8], 8'hFF});
  wire [15:0] fill    = org ? data_n : {2{data_n[7:0]}};
  wire [15:0] rd_load = org ? cur : (hi ? {cur[15:8], 8'h00} : {cur[7:0], 8'h00});

  assign sdo_en = cs && ((st == S_READ) || stat);
  assign sdo    = (st == S_READ) ? do_q : !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sclk_q   <= 1'b0;
      cnt      <= '0;
      op       <= '0;
      addr     <= '0;
      data     <= '0;
      wen      <= 1'b0;
      busy_cnt <= '0;
      stat     <= 1'b0;
      rd_sh    <= '0;
      rd_left  <= '0;
      do_q     <= 1'b0;
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else begin
      sclk_q <= sclk;
      if (busy) busy_cnt <= busy_cnt - BUSY_W'(1);
      if (!cs) begin
        st <= S_IDLE;
        if (!busy) stat <= 1'b0;
      end else begin
        case (st)
          S_IDLE: if (start) begin
            st   <= S_SHIFT;
            cnt  <= '0;
            op   <= '0;
            addr <= '0;
            data <= '0;
            stat <= 1'b0;
          end
          S_SHIFT: if (rise) begin
            cnt  <= cnt + CNT_W'(1);
            op   <= op_n;
            addr <= addr_n;
            data <= data_n;
            if (last) begin
              st <= S_IDLE;
              if (op_n == 2'b10) begin
                st      <= S_READ;
                rd_sh   <= rd_load;
                rd_left <= 5'(dw);
                do_q    <= 1'b0;
              end else if (op_n == 2'b00 && ext == 2'b11) begin
                wen <= 1'b1;
              end else if (op_n == 2'b00 && ext == 2'b00) begin
                wen <= 1'b0;
              end else if (wen) begin
                busy_cnt <= BUSY_W'(PROG_CYCLES);
                stat     <= 1'b1;
                if (op_n == 2'b01) mem[widx] <= wr_word;
                else if (op_n == 2'b11) mem[widx] <= er_word;
                else if (ext == 2'b10) for (int i = 0; i < WORDS; i++) mem[i] <= 16'hFFFF;
                else for (int i = 0; i < WORDS; i++) mem[i] <= fill;
              end
            end
          end
          S_READ: if (rise) begin
            if (rd_left != '0) begin
              do_q    <= rd_sh[15];
              rd_sh   <= {rd_sh[14:0], 1'b0};
              rd_left <= rd_left - 5'd1;
            end else begin
              st <= S_IDLE;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_eeprom_chk.sv
module serial_eeprom_chk #(
  parameter int BUSY_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs,
  input logic              sdi,
  input logic [1:0]        st,
  input logic              rise,
  input logic              wen,
  input logic [BUSY_W-1:0] busy_cnt,
  input logic              stat,
  input logic              do_q
);
  p_prog_needs_wen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_cnt != '0 && $past(busy_cnt) == '0) |-> $past(wen));

  p_busy_countdown_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_cnt != '0) |=> (busy_cnt == $past(busy_cnt) - BUSY_W'(1)));

  p_start_qualified_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && $past(st) != 2'd1) |-> $past(cs && sdi && rise));

  p_read_bit_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && !rise) |=> $stable(do_q));

  p_status_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat) |-> ($past(!cs) || $past(cs && sdi && rise && st == 2'd0)));
endmodule

bind serial_eeprom_dev serial_eeprom_chk #(.BUSY_W(BUSY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .sdi(sdi), .st(st), .rise(rise),
  .wen(wen), .busy_cnt(busy_cnt), .stat(stat), .do_q(do_q)
);

// File: tb/serial_eeprom_dev_test.sv
module serial_eeprom_dev_test;
  localparam int A8   = 7;
  localparam int PROG = 20;
  localparam int NW   = 1 << (A8 - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic org = 1'b1;
  logic cs = 1'b0;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic sdo, sdo_en;

  always #5 clk = ~clk;

  serial_eeprom_dev #(.ADDR8_W(A8), .PROG_CYCLES(PROG)) uut (
    .clk(clk), .rst_n(rst_n), .org(org), .cs(cs), .sclk(sclk),
    .sdi(sdi), .sdo(sdo), .sdo_en(sdo_en)
  );

  int unsigned compared = 0;
  int unsigned mismatched = 0;
  bit checking = 1'b0;
  bit done = 1'b0;
  string req = "R12";
  logic exp_en = 1'b0;
  logic exp_val = 1'b0;
  logic [15:0] model [NW];
  bit model_wen = 1'b0;

  always @(negedge clk) begin
    if (checking && rst_n) begin
      compared++;
      if (sdo_en !== exp_en || (exp_en && sdo !== exp_val)) begin
        mismatched++;
        $display("FAIL %s: sdo_en=%b sdo=%b, expected sdo_en=%b sdo=%b at %0t",
                 req, sdo_en, sdo, exp_en, exp_val, $time);
      end
    end
  end

  initial begin
    #1500000;
    if (!done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic clk_bit(input logic b);
    sclk = 1'b0; sdi = b; tick();
    sclk = 1'b1; tick();
  endtask

  function automatic int aw();
    return org ? A8 - 1 : A8;
  endfunction

  function automatic int dw();
    return org ? 16 : 8;
  endfunction

  task automatic cs_up();
    cs = 1'b1; tick();
  endtask

  task automatic cs_down();
    cs = 1'b0; exp_en = 1'b0; sclk = 1'b0; sdi = 1'b0;
    tick(); tick();
  endtask

  task automatic send(input logic [1:0] op, input int a, input logic [15:0] d, input bit with_data);
    clk_bit(1'b1);
    clk_bit(op[1]); clk_bit(op[0]);
    for (int i = aw() - 1; i >= 0; i--) clk_bit(a[i]);
    if (with_data) for (int i = dw() - 1; i >= 0; i--) clk_bit(d[i]);
  endtask

  function automatic logic [15:0] model_get(input int a);
    if (org) return model[a];
    return (a % 2 == 1) ? {8'h00, model[a / 2][15:8]} : {8'h00, model[a / 2][7:0]};
  endfunction

  task automatic busy_wait(input int mode);
    exp_en = 1'b1; exp_val = 1'b0;
    if (mode == 1) begin
      repeat (3) tick();
      cs = 1'b0; exp_en = 1'b0;
      repeat (2) tick();
      cs = 1'b1; exp_en = 1'b1;
      repeat (PROG - 5) tick();
    end else if (mode == 2) begin
      repeat (3) clk_bit(1'b1);
      repeat (PROG - 6) tick();
    end else begin
      repeat (PROG) tick();
    end
    exp_val = 1'b1;
    repeat (3) tick();
  endtask

  task automatic do_read(input int a, input string r);
    logic [15:0] w;
    req = r;
    w = model_get(a);
    cs_up();
    send(2'b10, a, 16'h0, 1'b0);
    exp_en = 1'b1; exp_val = 1'b0;
    tick();
    for (int i = dw() - 1; i >= 0; i--) begin
      clk_bit(1'b0);
      exp_val = w[i];
    end
    clk_bit(1'b0);
    exp_en = 1'b0;
    clk_bit(1'b0);
    cs_down();
  endtask

  task automatic prog_done(input int mode);
    if (model_wen) busy_wait(mode);
    else repeat (4) tick();
    cs_down();
  endtask

  task automatic do_write(input int a, input logic [15:0] d, input int mode, input string r);
    req = r;
    cs_up();
    send(2'b01, a, d, 1'b1);
    if (model_wen) begin
      if (org) model[a] = d;
      else if (a % 2 == 1) model[a / 2][15:8] = d[7:0];
      else model[a / 2][7:0] = d[7:0];
    end
    prog_done(mode);
  endtask

  task automatic do_erase(input int a, input string r);
    req = r;
    cs_up();
    send(2'b11, a, 16'h0, 1'b0);
    if (model_wen) begin
      if (org) model[a] = 16'hFFFF;
      else if (a % 2 == 1) model[a / 2][15:8] = 8'hFF;
      else model[a / 2][7:0] = 8'hFF;
    end
    prog_done(0);
  endtask

  task automatic do_ext(input logic [1:0] code, input logic [15:0] d, input string r);
    int a;
    req = r;
    a = int'(code) << (aw() - 2);
    cs_up();
    send(2'b00, a, d, code == 2'b01);
    if (code == 2'b11) model_wen = 1'b1;
    else if (code == 2'b00) model_wen = 1'b0;
    if (code == 2'b10 || code == 2'b01) begin
      if (model_wen)
        for (int i = 0; i < NW; i++) model[i] = (code == 2'b10) ? 16'hFFFF : (org ? d : {2{d[7:0]}});
      prog_done(0);
    end else begin
      repeat (2) tick();
      cs_down();
    end
  endtask

  initial begin
    for (int i = 0; i < NW; i++) model[i] = 16'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    checking = 1'b1;
    // R12: reset state, outputs floating
    req = "R12"; repeat (4) tick();
    do_read(0, "R12");
    // R8: write refused while latch clear
    do_write(5, 16'hA5A5, 0, "R8");
    do_read(5, "R8");
    // R2: edges with cs low and leading zeros start nothing
    req = "R2";
    sdi = 1'b1; repeat (3) begin sclk = 1'b1; tick(); tick(); sclk = 1'b0; tick(); tick(); end
    cs_up();
    repeat (3) clk_bit(1'b0);
    cs_down();
    // R3: enable, then R5 trailing zeros ignored
    req = "R3"; cs_up();
    repeat (2) clk_bit(1'b0);
    send(2'b00, 3 << (aw() - 2), 16'h0, 1'b0);
    model_wen = 1'b1;
    req = "R5"; repeat (5) clk_bit(1'b0);
    cs_down();
    // R10, R7: programming with busy flag, read back
    do_write(5, 16'hA5A5, 0, "R10");
    do_read(5, "R7");
    do_write(9, 16'h1234, 1, "R10");
    do_read(9, "R7");
    // R1: byte view of the same storage
    org = 1'b0;
    do_read(10, "R1"); do_read(11, "R1"); do_read(18, "R1"); do_read(19, "R1");
    do_write(19, 16'h007E, 2, "R10");
    org = 1'b1;
    do_read(9, "R1");
    // R11: erase of word and byte
    do_erase(5, "R11");
    do_read(5, "R11");
    org = 1'b0;
    do_erase(18, "R11");
    org = 1'b1;
    do_read(9, "R11");
    // R4: aborted write
    req = "R4"; cs_up();
    clk_bit(1'b1); clk_bit(1'b0); clk_bit(1'b1);
    for (int i = aw() - 1; i >= 0; i--) clk_bit(3 >> i);
    repeat (6) clk_bit(1'b1);
    cs_down();
    do_read(3, "R4");
    // R9: read with latch clear; R8: programming refused
    do_ext(2'b00, 16'h0, "R8");
    do_read(9, "R9");
    do_write(9, 16'h5555, 0, "R8");
    do_ext(2'b10, 16'h0, "R8");
    do_read(9, "R8");
    do_read(5, "R9");
    // R11: write-all and erase-all
    do_ext(2'b11, 16'h0, "R3");
    org = 1'b0;
    do_ext(2'b01, 16'h003C, "R11");
    do_read(7, "R11");
    org = 1'b1;
    do_read(40, "R11");
    do_ext(2'b10, 16'h0, "R11");
    do_read(63, "R11");
    do_ext(2'b01, 16'hBEEF, "R11");
    do_read(0, "R11"); do_read(33, "R11");
    org = 1'b0;
    do_read(1, "R1");
    repeat (4) tick();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule